// File: doc/BRIEF.md
# CAN Controller Bus-Side Register Block

This block is the processor-facing register file of a CAN controller. It sits on an APB segment as a slave with 32-bit word registers at offsets 0x00 to 0x28. It holds the configuration word, the acceptance filter, the three-word transmit buffer and the trigger pattern, and hands all of them to the protocol engine as plain outputs. On reads it presents a status word, the three received-frame words and both error counters, all taken straight from the engine's outputs.

The configuration word also carries command bits. Request-to-send stays set until the engine reports the frame sent. Interrupt-clear, engine-reset and receive-clear act once and are never stored. A latched interrupt line collects the enabled engine events. It stays high until software clears it.

Top module: `can_apb_regs`

## Requirements
- R1: After a synchronous reset, SETUP (0x00) reads 0x00008000 (only the disable bit 15 set), every status flag is 0, `irq` is 0 and `core_rst` is 1.
- R2: A write takes effect only when `psel`, `penable` and `pwrite` are all high. SETUP keeps bits 0..28, FILTER (0x08) keeps mask 0x07FF07FF, TX word 0 (0x0C) keeps 0x1FFFFFFF, TX words 1 and 2 (0x10, 0x14) keep all 32 bits and TRIGGER (0x28) keeps 0x000007FF. Other bits read 0.
- R3: 0x18/0x1C/0x20 return `rx_arb`/`rx_data_lo`/`rx_data_hi`. 0x24 returns `tx_err_cnt` in bits 7:0 and `rx_err_cnt` in bits 15:8. Writes to 0x04 to 0x24 read-only words change nothing.
- R4: `prdata` is 0 unless `psel`=1, `pwrite`=0, `paddr[1:0]`=0 and the offset is at most 0x28. A write to an address with nonzero low bits changes nothing.
- R5: SETUP bits 29 (interrupt clear), 30 (engine reset) and 31 (receive clear) always read back as 0.
- R6: Writing SETUP with bit 27 = 1 sets the request bit and clears TX-ok (STATUS bit 3), and this clear wins over a same-cycle `core_tx_done`. `core_tx_done` clears bit 27 and sets TX-ok. STATUS bit 2 shows a pending request.
- R7: `core_rx_done` sets RX-ok (STATUS bit 4). `core_rx_done` while RX-ok is already 1 sets overrun (STATUS bit 5). A SETUP write with bit 31 clears both, and with a same-cycle `core_rx_done` it leaves RX-ok 1 and overrun 0.
- R8: `core_sync_rx` sets STATUS bit 6 only when SETUP bit 4 is 1. `core_sync_tx` sets STATUS bit 7 only when SETUP bit 5 is 1. A SETUP write with bit 29 clears both, unless a set happens in the same cycle.
- R9: `irq` rises one cycle after any enabled source: `core_tx_done` with SETUP bit 0, `core_rx_done` with bit 1, an overrun event with bit 2, or `core_err_pass`/`core_bus_off` high with bit 3. It then holds until a SETUP write with bit 29, and it stays set if a source is active in that cycle.
- R10: A SETUP write with bit 30 drives `core_rst` high for exactly one cycle. `core_rst` is also high for as long as SETUP bit 15 is 1.
- R11: STATUS bit 0 shows `core_bus_off`, bit 1 shows `core_err_pass`, bits 11:8 show `rx_dlc` and bit 12 shows `rx_ext`. Bits 31:13 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| core_tx_done | input | 1 | Engine: frame sent (pulse) |
| core_rx_done | input | 1 | Engine: accepted frame received (pulse) |
| core_err_pass | input | 1 | Engine: error-passive level |
| core_bus_off | input | 1 | Engine: bus-off level |
| core_sync_rx | input | 1 | Engine: sync edge seen on received frame |
| core_sync_tx | input | 1 | Engine: sync edge seen on sent frame |
| rx_arb | input | 32 | Received arbitration word |
| rx_data_lo | input | 32 | Received data bytes 0..3 |
| rx_data_hi | input | 32 | Received data bytes 4..7 |
| rx_dlc | input | 4 | Received length code |
| rx_ext | input | 1 | Received frame uses an extended identifier |
| tx_err_cnt | input | CNT_W | Engine transmit error counter |
| rx_err_cnt | input | CNT_W | Engine receive error counter |
| cfg_setup | output | 32 | Stored configuration word |
| cfg_filter | output | 32 | Acceptance mask and code |
| tx_word0 | output | 32 | Transmit arbitration word |
| tx_word1 | output | 32 | Transmit data bytes 0..3 |
| tx_word2 | output | 32 | Transmit data bytes 4..7 |
| cfg_trig | output | 32 | Trigger pattern |
| irq | output | 1 | Latched interrupt request |
| core_rst | output | 1 | Reset to the protocol engine |

## Verification
A wrong flag state shows up one cycle after the engine event that caused it, through the STATUS read and the `irq` line. A lost or stuck command strobe shows up in the cycle after the write, either at `core_rst` or as a flag that does not clear. The same-cycle collisions between a command write and an engine event are driven on purpose, because those cycles decide which side wins. Corrupted storage or a wrong field mask shows up on the next read of that word, and random register traffic is mixed in to find it.

// File: rtl/can_apb_pkg.sv
package can_apb_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 11;

  // word indices (byte offset / 4)
  localparam int W_SETUP  = 0;
  localparam int W_STATUS = 1;
  localparam int W_FILTER = 2;
  localparam int W_TX0    = 3;
  localparam int W_TX1    = 4;
  localparam int W_TX2    = 5;
  localparam int W_RX0    = 6;
  localparam int W_RX1    = 7;
  localparam int W_RX2    = 8;
  localparam int W_ERRC   = 9;
  localparam int W_TRIG   = 10;

  // SETUP bit positions
  localparam int B_EN_TX     = 0;
  localparam int B_EN_RX     = 1;
  localparam int B_EN_OVR    = 2;
  localparam int B_EN_ERR    = 3;
  localparam int B_SYNC_RX   = 4;
  localparam int B_SYNC_TX   = 5;
  localparam int B_DISABLE   = 15;
  localparam int B_TXREQ     = 27;
  localparam int B_INTCLR    = 29;
  localparam int B_CORE_RST  = 30;
  localparam int B_RXCLR     = 31;

  localparam logic [DATA_W-1:0] SETUP_KEEP  = 32'h1FFF_FFFF;
  localparam logic [DATA_W-1:0] SETUP_RESET = 32'h0000_8000;

  typedef struct packed {
    logic sync_tx;
    logic sync_rx;
    logic overrun;
    logic rx_ok;
    logic tx_ok;
  } flags_t;

  // storage mask of the plain read/write words; 0 means not a plain word
  function automatic logic [DATA_W-1:0] rw_mask(int idx);
    case (idx)
      W_FILTER: return 32'h07FF_07FF;
      W_TX0:    return 32'h1FFF_FFFF;
      W_TX1:    return 32'hFFFF_FFFF;
      W_TX2:    return 32'hFFFF_FFFF;
      W_TRIG:   return 32'h0000_07FF;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/can_apb_decode.sv
module can_apb_decode
  import can_apb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic [NUM_WORDS-1:0] wr_sel,
  output logic [NUM_WORDS-1:0] rd_sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign aligned = (paddr[1:0] == 2'b00);
  assign idx     = paddr[ADDR_W-1:2];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_sel
    logic hit;
    assign hit       = aligned && (idx == IDX_W'(g));
    assign wr_sel[g] = hit && psel && penable && pwrite;
    assign rd_sel[g] = hit && psel && !pwrite;
  end
endmodule

// File: rtl/can_apb_setup.sv
module can_apb_setup
  import can_apb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_done,
  output logic [DATA_W-1:0] setup_q,
  output logic              intclr_p,
  output logic              rxclr_p,
  output logic              txreq_p,
  output logic              core_rst
);
  logic rst_pulse_q;

  assign intclr_p = wr && wdata[B_INTCLR];
  assign rxclr_p  = wr && wdata[B_RXCLR];
  assign txreq_p  = wr && wdata[B_TXREQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q     <= SETUP_RESET;
      rst_pulse_q <= 1'b0;
    end else begin
      rst_pulse_q <= wr && wdata[B_CORE_RST];
      if (wr)
        setup_q <= wdata & SETUP_KEEP;
      else if (tx_done)
        setup_q[B_TXREQ] <= 1'b0;
    end
  end

  assign core_rst = rst_pulse_q || setup_q[B_DISABLE];
endmodule

// File: rtl/can_apb_status.sv
module can_apb_status
  import can_apb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en_tx,
  input  logic   en_rx,
  input  logic   en_ovr,
  input  logic   en_err,
  input  logic   en_sync_rx,
  input  logic   en_sync_tx,
  input  logic   intclr_p,
  input  logic   rxclr_p,
  input  logic   txreq_p,
  input  logic   tx_done,
  input  logic   rx_done,
  input  logic   err_pass,
  input  logic   bus_off,
  input  logic   sync_rx,
  input  logic   sync_tx,
  output flags_t flags,
  output logic   irq
);
  logic ovr_evt, srx_set, stx_set, irq_src;

  assign ovr_evt = rx_done && flags.rx_ok;
  assign srx_set = sync_rx && en_sync_rx;
  assign stx_set = sync_tx && en_sync_tx;
  assign irq_src = (tx_done && en_tx) || (rx_done && en_rx) ||
                   (ovr_evt && en_ovr) || ((err_pass || bus_off) && en_err);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      if (txreq_p)      flags.tx_ok <= 1'b0;
      else if (tx_done) flags.tx_ok <= 1'b1;

      if (rx_done)      flags.rx_ok <= 1'b1;
      else if (rxclr_p) flags.rx_ok <= 1'b0;

      if (rxclr_p)      flags.overrun <= 1'b0;
      else if (ovr_evt) flags.overrun <= 1'b1;

      if (srx_set)       flags.sync_rx <= 1'b1;
      else if (intclr_p) flags.sync_rx <= 1'b0;

      if (stx_set)       flags.sync_tx <= 1'b1;
      else if (intclr_p) flags.sync_tx <= 1'b0;

      if (irq_src)       irq <= 1'b1;
      else if (intclr_p) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/can_apb_regs.sv
module can_apb_regs
  import can_apb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int DLC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              core_tx_done,
  input  logic              core_rx_done,
  input  logic              core_err_pass,
  input  logic              core_bus_off,
  input  logic              core_sync_rx,
  input  logic              core_sync_tx,
  input  logic [31:0]       rx_arb,
  input  logic [31:0]       rx_data_lo,
  input  logic [31:0]       rx_data_hi,
  input  logic [DLC_W-1:0]  rx_dlc,
  input  logic              rx_ext,
  input  logic [CNT_W-1:0]  tx_err_cnt,
  input  logic [CNT_W-1:0]  rx_err_cnt,
  output logic [31:0]       cfg_setup,
  output logic [31:0]       cfg_filter,
  output logic [31:0]       tx_word0,
  output logic [31:0]       tx_word1,
  output logic [31:0]       tx_word2,
  output logic [31:0]       cfg_trig,
  output logic              irq,
  output logic              core_rst
);
  localparam int STAT_USED = 8 + DLC_W + 1;
  localparam int CNT_USED  = 2 * CNT_W;

  logic [NUM_WORDS-1:0] wr_sel, rd_sel;
  logic [DATA_W-1:0]    setup_q;
  logic                 intclr_p, rxclr_p, txreq_p;
  flags_t               flags;
  logic [DATA_W-1:0]    status_w;
  logic [DATA_W-1:0]    word_v [NUM_WORDS];
  logic [DATA_W-1:0]    rw_q   [NUM_WORDS];

  can_apb_decode #(.ADDR_W(ADDR_W)) i_decode (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  can_apb_setup i_setup (
    .clk(clk), .rst(rst), .wr(wr_sel[W_SETUP]), .wdata(pwdata),
    .tx_done(core_tx_done), .setup_q(setup_q), .intclr_p(intclr_p),
    .rxclr_p(rxclr_p), .txreq_p(txreq_p), .core_rst(core_rst)
  );

  can_apb_status i_status (
    .clk(clk), .rst(rst),
    .en_tx(setup_q[B_EN_TX]), .en_rx(setup_q[B_EN_RX]),
    .en_ovr(setup_q[B_EN_OVR]), .en_err(setup_q[B_EN_ERR]),
    .en_sync_rx(setup_q[B_SYNC_RX]), .en_sync_tx(setup_q[B_SYNC_TX]),
    .intclr_p(intclr_p), .rxclr_p(rxclr_p), .txreq_p(txreq_p),
    .tx_done(core_tx_done), .rx_done(core_rx_done),
    .err_pass(core_err_pass), .bus_off(core_bus_off),
    .sync_rx(core_sync_rx), .sync_tx(core_sync_tx),
    .flags(flags), .irq(irq)
  );

  // plain read/write words
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    if (rw_mask(g) != '0) begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)            q <= '0;
        else if (wr_sel[g]) q <= pwdata & rw_mask(g);
      end
      assign rw_q[g] = q;
    end else begin : g_none
      assign rw_q[g] = '0;
    end
  end

  assign status_w = {{(DATA_W-STAT_USED){1'b0}}, rx_ext, rx_dlc,
                     flags.sync_tx, flags.sync_rx, flags.overrun,
                     flags.rx_ok, flags.tx_ok, setup_q[B_TXREQ],
                     core_err_pass, core_bus_off};

  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++) word_v[i] = rw_q[i];
    word_v[W_SETUP]  = setup_q;
    word_v[W_STATUS] = status_w;
    word_v[W_RX0]    = rx_arb;
    word_v[W_RX1]    = rx_data_lo;
    word_v[W_RX2]    = rx_data_hi;
    word_v[W_ERRC]   = {{(DATA_W-CNT_USED){1'b0}}, rx_err_cnt, tx_err_cnt};
  end

  always_comb begin
    prdata = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (rd_sel[i]) prdata = prdata | word_v[i];
  end

  assign cfg_setup  = setup_q;
  assign cfg_filter = rw_q[W_FILTER];
  assign tx_word0   = rw_q[W_TX0];
  assign tx_word1   = rw_q[W_TX1];
  assign tx_word2   = rw_q[W_TX2];
  assign cfg_trig   = rw_q[W_TRIG];
endmodule

// File: rtl/can_apb_regs_chk.sv
module can_apb_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              core_tx_done,
  input logic              core_rx_done,
  input logic              irq,
  input logic              core_rst,
  input logic [31:0]       status_w
);
  logic setup_wr;
  assign setup_wr = psel && penable && pwrite && (paddr == '0);

  // R10
  core_rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (setup_wr && pwdata[30]) |=> core_rst);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !(setup_wr && pwdata[29])) |=> irq);

  // R4
  stray_read_chk: assert property (@(posedge clk) disable iff (rst)
    (psel && !pwrite && (paddr[1:0] != 2'b00)) |-> (prdata == '0));

  // R6
  tx_ok_set_chk: assert property (@(posedge clk) disable iff (rst)
    (core_tx_done && !(setup_wr && pwdata[27])) |=> status_w[3]);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (core_rx_done && status_w[4] && !(setup_wr && pwdata[31])) |=> status_w[5]);

  // R7
  rx_ok_set_chk: assert property (@(posedge clk) disable iff (rst)
    core_rx_done |=> status_w[4]);
endmodule

bind can_apb_regs can_apb_regs_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
  .core_tx_done(core_tx_done), .core_rx_done(core_rx_done),
  .irq(irq), .core_rst(core_rst), .status_w(status_w)
);

// File: tb/test_can_apb_regs.sv
module test_can_apb_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic tx_done = 0, rx_done = 0, err_pass = 0, bus_off = 0, sync_rx = 0, sync_tx = 0;
  logic [31:0] rx_arb = '0, rx_lo = '0, rx_hi = '0;
  logic [3:0] rx_dlc = '0;
  logic rx_ext = 0;
  logic [7:0] tx_ec = '0, rx_ec = '0;
  logic [31:0] cfg_setup, cfg_filter, tx_word0, tx_word1, tx_word2, cfg_trig;
  logic irq, core_rst;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  logic [31:0] m_setup = 32'h0000_8000;
  logic [31:0] m_rw [11];
  logic m_txok = 0, m_rxok = 0, m_ovr = 0, m_srx = 0, m_stx = 0, m_irq = 0;

  can_apb_regs #(.ADDR_W(ADDR_W)) i_can_apb_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .core_tx_done(tx_done), .core_rx_done(rx_done), .core_err_pass(err_pass),
    .core_bus_off(bus_off), .core_sync_rx(sync_rx), .core_sync_tx(sync_tx),
    .rx_arb(rx_arb), .rx_data_lo(rx_lo), .rx_data_hi(rx_hi), .rx_dlc(rx_dlc),
    .rx_ext(rx_ext), .tx_err_cnt(tx_ec), .rx_err_cnt(rx_ec),
    .cfg_setup(cfg_setup), .cfg_filter(cfg_filter), .tx_word0(tx_word0),
    .tx_word1(tx_word1), .tx_word2(tx_word2), .cfg_trig(cfg_trig),
    .irq(irq), .core_rst(core_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] keep_mask(int idx);
    case (idx)
      2: return 32'h07FF_07FF;
      3: return 32'h1FFF_FFFF;
      4, 5: return 32'hFFFF_FFFF;
      10: return 32'h0000_07FF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [ADDR_W-1:0] a);
    int idx;
    idx = int'(a[ADDR_W-1:2]);
    if (a[1:0] != 2'b00 || idx > 10) return 32'h0;
    case (idx)
      0: return m_setup;
      1: return {19'h0, rx_ext, rx_dlc, m_stx, m_srx, m_ovr, m_rxok, m_txok,
                 m_setup[27], err_pass, bus_off};
      6: return rx_arb;
      7: return rx_lo;
      8: return rx_hi;
      9: return {16'h0, rx_ec, tx_ec};
      default: return m_rw[idx];
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic model_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    int idx;
    idx = int'(a[ADDR_W-1:2]);
    if (a[1:0] != 2'b00 || idx > 10) return;
    if (idx == 0) begin
      m_setup = d & 32'h1FFF_FFFF;
      if (d[27]) m_txok = 0;
      if (d[31]) begin m_rxok = 0; m_ovr = 0; end
      if (d[29]) begin m_irq = 0; m_srx = 0; m_stx = 0; end
    end else if (keep_mask(idx) != 0) begin
      m_rw[idx] = d & keep_mask(idx);
    end
  endtask

  // write; ev bits raise tx_done(0)/rx_done(1) during the access cycle
  task automatic apb_wr(logic [ADDR_W-1:0] a, logic [31:0] d, logic [1:0] ev = 2'b00);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1; tx_done = ev[0]; rx_done = ev[1];
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; tx_done = 0; rx_done = 0;
    model_write(a, d);
  endtask

  task automatic apb_rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic rd_check(string req, logic [ADDR_W-1:0] a);
    logic [31:0] d;
    apb_rd(a, d);
    check(req, d, exp_read(a));
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    m_txok = 1; m_setup[27] = 0;
    if (m_setup[0]) m_irq = 1;
  endtask

  task automatic pulse_rx();
    @(negedge clk); rx_done = 1;
    @(negedge clk); rx_done = 0;
    if (m_rxok) begin m_ovr = 1; if (m_setup[2]) m_irq = 1; end
    m_rxok = 1;
    if (m_setup[1]) m_irq = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int seed;
    for (int i = 0; i < 11; i++) m_rw[i] = '0;
    seed = $urandom(32'hC0DE_1234);
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd_check("R1 setup", 8'h00);
    rd_check("R1 status", 8'h04);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 core_rst", {31'h0, core_rst}, 32'h1);

    // R10 disable then one-shot reset
    apb_wr(8'h00, 32'h0);
    check("R10 enable", {31'h0, core_rst}, 32'h0);
    apb_wr(8'h00, 32'h4000_0000);
    check("R10 pulse", {31'h0, core_rst}, 32'h1);
    @(negedge clk);
    check("R10 one cycle", {31'h0, core_rst}, 32'h0);
    // R5 command bits read 0
    apb_wr(8'h00, 32'hE000_00F0);
    rd_check("R5 cmd bits", 8'h00);

    // R2 masks
    apb_wr(8'h08, 32'hFFFF_FFFF); rd_check("R2 filter", 8'h08);
    apb_wr(8'h0C, 32'hFFFF_FFFF); rd_check("R2 tx0", 8'h0C);
    apb_wr(8'h14, 32'hA5A5_5A5A); rd_check("R2 tx2", 8'h14);
    apb_wr(8'h28, 32'hFFFF_FFFF); rd_check("R2 trig", 8'h28);
    // R2 no access phase: setup-only cycle
    @(negedge clk); psel = 1; pwrite = 1; paddr = 8'h10; pwdata = 32'h1234_5678;
    @(negedge clk); psel = 0; pwrite = 0;
    rd_check("R2 no penable", 8'h10);

    // R4 stray addresses
    rx_arb = 32'hDEAD_BEEF;
    rd_check("R4 misaligned", 8'h03);
    rd_check("R4 beyond map", 8'h2C);
    apb_wr(8'h0A, 32'h0000_0123);
    rd_check("R4 misaligned write", 8'h08);

    // R3 / R11 read-only words
    rx_lo = 32'h0102_0304; rx_hi = 32'hF0E0_D0C0; tx_ec = 8'h7F; rx_ec = 8'h81;
    rx_dlc = 4'h8; rx_ext = 1; bus_off = 1;
    rd_check("R3 rx0", 8'h18);
    rd_check("R3 rx1", 8'h1C);
    rd_check("R3 rx2", 8'h20);
    rd_check("R3 errcnt", 8'h24);
    rd_check("R11 status", 8'h04);
    apb_wr(8'h04, 32'hFFFF_FFFF);
    rd_check("R3 status write ignored", 8'h04);
    apb_wr(8'h24, 32'hFFFF_FFFF);
    rd_check("R3 errcnt write ignored", 8'h24);
    bus_off = 0; err_pass = 1;
    rd_check("R11 errpass", 8'h04);
    err_pass = 0;

    // R6 transmit request
    apb_wr(8'h00, 32'h0800_0007);
    rd_check("R6 active", 8'h04);
    pulse_tx();
    check("R9 irq tx", {31'h0, irq}, 32'h1);
    rd_check("R6 txok", 8'h04);
    rd_check("R6 req cleared", 8'h00);
    repeat (5) @(negedge clk);
    check("R9 irq held", {31'h0, irq}, 32'h1);
    apb_wr(8'h00, 32'h2000_0006);
    check("R9 irq cleared", {31'h0, irq}, 32'h0);
    apb_wr(8'h00, 32'h0800_0006, 2'b01); // request wins over same-cycle done
    m_txok = 0; m_setup[27] = 1;
    rd_check("R6 clear wins", 8'h04);

    // R7 receive
    pulse_rx();
    rd_check("R7 rxok", 8'h04);
    pulse_rx();
    rd_check("R7 overrun", 8'h04);
    check("R9 irq rx", {31'h0, irq}, 32'h1);
    apb_wr(8'h00, 32'hA000_0000);
    rd_check("R7 rxclr", 8'h04);
    pulse_rx();
    apb_wr(8'h00, 32'h8000_0000, 2'b10);
    m_rxok = 1; m_ovr = 0;
    rd_check("R7 clear with rx", 8'h04);

    // R8 sync flags
    apb_wr(8'h00, 32'h0000_0010);
    @(negedge clk); sync_rx = 1; sync_tx = 1;
    @(negedge clk); sync_rx = 0; sync_tx = 0;
    m_srx = 1;
    rd_check("R8 sync", 8'h04);
    apb_wr(8'h00, 32'h2000_0010);
    rd_check("R8 intclr", 8'h04);

    // R9 error level
    apb_wr(8'h00, 32'h0000_0008);
    @(negedge clk); err_pass = 1;
    @(negedge clk);
    check("R9 err irq", {31'h0, irq}, 32'h1);
    apb_wr(8'h00, 32'h2000_0008);
    check("R9 level rearms", {31'h0, irq}, 32'h1);
    err_pass = 0;
    apb_wr(8'h00, 32'h2000_0008);
    check("R9 cleared", {31'h0, irq}, 32'h0);
    m_irq = 0;

    // random register traffic
    for (int it = 0; it < 400; it++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0] wd;
      a = ADDR_W'($urandom_range(0, 12) * 4);
      if ($urandom_range(0, 7) == 0) a = a | ADDR_W'($urandom_range(1, 3));
      wd = $urandom;
      wd[29] = 0; // leave irq model unaffected
      if ($urandom_range(0, 1) == 0) apb_wr(a, wd);
      else rd_check("R2 random", a);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule